// File: doc/BRIEF.md
# Dual-Channel Min/Max/Average Accumulator

This block watches two 16-bit sample streams, called P and N, each with its own strobe. For every channel it holds the most recent sample, the lowest and highest sample seen since the last restart, and a running average whose rate of change is set by a per-channel weight. Each packed result word carries P in its upper half and N in its lower half.

A sample counter runs against a programmable accumulation length. The block has two validity levels. The early flag says that the results already hold data. The final flag says that the full count has been reached. At that point the results freeze, and a one-cycle done pulse goes to the interrupt logic. Lowering the global enable acts as a restart. It clears the flags, the counter and every result register, and no sample is taken while it stays low.

Top module: `minmax_avg_accum`

## Requirements
- R1: The latest-value word holds the last accepted P sample in bits 31:16 and the last accepted N sample in bits 15:0. The minimum, maximum and average words use the same packing.
- R2: After a restart each minimum half reads 0xFFFF and each maximum half reads 0x0000. Every accepted sample then lowers the minimum or raises the maximum of its channel where it goes beyond them.
- R3: On every accepted sample the channel average becomes avg + floor(((sample − avg) × weight) / 65536), with the difference signed and the weight unsigned. A weight of 0 leaves the average unchanged.
- R4: A channel accepts a sample only in a cycle where its strobe, its channel enable, the detector enable and the global enable are all high and the final flag is low. Otherwise none of that channel's results change.
- R5: The counter advances by one in each cycle where at least one channel accepts a sample. The final flag rises in the cycle after the counter reaches the programmed length. A length of 0 behaves like a length of 1.
- R6: The early flag rises in the cycle after the first accepted sample following a restart, and it stays high while the final flag is high.
- R7: The done pulse is high for exactly one cycle, in the same cycle the final flag rises. After that no result changes until the next restart.
- R8: While the global enable is low, on each clock both flags and the done pulse go low, the counter clears, the minimum, maximum and average halves return to their restart values, and the latest values read 0.
- R9: The asynchronous reset leaves the block in the same state that R8 produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global enable; low clears the block and holds it in restart |
| det_en | input | 1 | Detector enable |
| chp_en | input | 1 | P channel enable |
| chn_en | input | 1 | N channel enable |
| accum_len | input | 10 | Number of sample cycles to accumulate |
| wgt_p | input | 16 | P average weight |
| wgt_n | input | 16 | N average weight |
| samp_p | input | 16 | P sample |
| stb_p | input | 1 | P sample strobe |
| samp_n | input | 16 | N sample |
| stb_n | input | 1 | N sample strobe |
| latest_o | output | 32 | Latest samples, P in 31:16 and N in 15:0 |
| min_o | output | 32 | Minimum samples, packed the same way |
| max_o | output | 32 | Maximum samples, packed the same way |
| avg_o | output | 32 | Running averages, packed the same way |
| early_valid | output | 1 | Results hold data |
| final_valid | output | 1 | Accumulation complete |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach is the freeze after completion while the strobes are still active. It takes a full run up to the programmed length, followed by further samples that would otherwise change the minimum, the maximum and the average. The stimulus table uses a short length and keeps strobing past the count with values outside the current range, so any leak through the freeze shows up. A second run checks that lowering the global enable lets a new accumulation start.

// File: rtl/minmax_avg_accum.sv
module minmax_avg_accum #(
  parameter int DW = 16,
  parameter int LW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            glob_en,
  input  logic            det_en,
  input  logic            chp_en,
  input  logic            chn_en,
  input  logic [LW-1:0]   accum_len,
  input  logic [DW-1:0]   wgt_p,
  input  logic [DW-1:0]   wgt_n,
  input  logic [DW-1:0]   samp_p,
  input  logic            stb_p,
  input  logic [DW-1:0]   samp_n,
  input  logic            stb_n,
  output logic [2*DW-1:0] latest_o,
  output logic [2*DW-1:0] min_o,
  output logic [2*DW-1:0] max_o,
  output logic [2*DW-1:0] avg_o,
  output logic            early_valid,
  output logic            final_valid,
  output logic            done_pulse
);
  localparam int PW = 2*DW + 2;

  logic [LW-1:0] cnt;
  logic [LW:0]   cnt_inc;
  logic          run, hit;
  logic [1:0]    acc;

  assign run     = glob_en && det_en && !final_valid;
  assign acc[0]  = run && chn_en && stb_n;
  assign acc[1]  = run && chp_en && stb_p;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign hit     = cnt_inc >= {1'b0, accum_len};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [DW-1:0]        lat, mn, mx, av, s, w;
    logic signed [DW:0]   diff;
    logic signed [PW-1:0] prod, nxt;

    assign s    = (ch == 1) ? samp_p : samp_n;
    assign w    = (ch == 1) ? wgt_p  : wgt_n;
    assign diff = $signed({1'b0, s}) - $signed({1'b0, av});
    assign prod = diff * $signed({1'b0, w});
    assign nxt  = $signed({{(DW+2){1'b0}}, av}) + (prod >>> DW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat <= '0; mn <= '1; mx <= '0; av <= '0;
      end else if (!glob_en) begin
        lat <= '0; mn <= '1; mx <= '0; av <= '0;
      end else if (acc[ch]) begin
        lat <= s;
        av  <= nxt[DW-1:0];
        if (s < mn) mn <= s;
        if (s > mx) mx <= s;
      end
    end

    assert_avg_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      nxt[PW-1:DW] == '0);
  end

  assign latest_o = {g_ch[1].lat, g_ch[0].lat};
  assign min_o    = {g_ch[1].mn,  g_ch[0].mn};
  assign max_o    = {g_ch[1].mx,  g_ch[0].mx};
  assign avg_o    = {g_ch[1].av,  g_ch[0].av};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; early_valid <= 1'b0; final_valid <= 1'b0; done_pulse <= 1'b0;
    end else if (!glob_en) begin
      cnt <= '0; early_valid <= 1'b0; final_valid <= 1'b0; done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (|acc) begin
        cnt         <= cnt_inc[LW-1:0];
        early_valid <= 1'b1;
        if (hit) begin
          final_valid <= 1'b1;
          done_pulse  <= 1'b1;
        end
      end
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> (!early_valid && !final_valid && !done_pulse &&
                  min_o == '1 && max_o == '0 && avg_o == '0 && latest_o == '0));

  assert_final_implies_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    final_valid |-> early_valid);

  assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(final_valid) |-> done_pulse);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (final_valid && glob_en) |=> ($stable(latest_o) && $stable(min_o) &&
                                  $stable(max_o) && $stable(avg_o)));

  assert_det_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_en && !det_en) |=> ($stable(latest_o) && $stable(min_o) &&
                              $stable(max_o) && $stable(avg_o) && $stable(early_valid)));
endmodule

// File: tb/minmax_avg_accum_tb.sv
`timescale 1ns/1ps
module minmax_avg_accum_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic glob_en, det_en, chp_en, chn_en, stb_p, stb_n;
  logic [9:0] accum_len;
  logic [15:0] wgt_p, wgt_n, samp_p, samp_n;
  logic [31:0] latest_o, min_o, max_o, avg_o;
  logic early_valid, final_valid, done_pulse;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_lat [2], m_min [2], m_max [2], m_avg [2];
  int m_cnt;
  logic m_early, m_final, m_done;

  always #2 clk = ~clk;

  minmax_avg_accum u_dut (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .det_en(det_en),
    .chp_en(chp_en), .chn_en(chn_en), .accum_len(accum_len),
    .wgt_p(wgt_p), .wgt_n(wgt_n), .samp_p(samp_p), .stb_p(stb_p),
    .samp_n(samp_n), .stb_n(stb_n), .latest_o(latest_o), .min_o(min_o),
    .max_o(max_o), .avg_o(avg_o), .early_valid(early_valid),
    .final_valid(final_valid), .done_pulse(done_pulse));

  // {stb_p, stb_n, samp_p, samp_n}
  localparam logic [33:0] VEC [12] = '{
    {2'b11, 16'h1000, 16'h0200},
    {2'b01, 16'hFFFF, 16'h0100},
    {2'b10, 16'h0800, 16'h0000},
    {2'b00, 16'h0001, 16'h0001},
    {2'b11, 16'h2000, 16'h8000},
    {2'b11, 16'h0400, 16'h0050},
    {2'b10, 16'hF000, 16'h0000},
    {2'b11, 16'h0300, 16'h7FFF},
    {2'b01, 16'h0000, 16'h0003},
    {2'b11, 16'h0010, 16'hFFFE},
    {2'b11, 16'hFFFF, 16'h0000},
    {2'b11, 16'h0000, 16'hFFFF}
  };

  task automatic mdl_clear();
    for (int c = 0; c < 2; c++) begin
      m_lat[c] = '0; m_min[c] = '1; m_max[c] = '0; m_avg[c] = '0;
    end
    m_cnt = 0; m_early = 0; m_final = 0; m_done = 0;
  endtask

  function automatic logic [15:0] avg_step(logic [15:0] a, logic [15:0] s, logic [15:0] w);
    longint d, t;
    d = longint'(s) - longint'(a);
    t = (d * longint'(w)) >>> 16;
    return 16'(longint'(a) + t);
  endfunction

  task automatic mdl_edge();
    logic [1:0] ac;
    logic [15:0] sv [2];
    logic [15:0] wv [2];
    if (!glob_en) begin mdl_clear(); return; end
    sv[0] = samp_n; sv[1] = samp_p; wv[0] = wgt_n; wv[1] = wgt_p;
    ac[0] = det_en && !m_final && chn_en && stb_n;
    ac[1] = det_en && !m_final && chp_en && stb_p;
    m_done = 0;
    for (int c = 0; c < 2; c++) if (ac[c]) begin
      m_lat[c] = sv[c];
      m_avg[c] = avg_step(m_avg[c], sv[c], wv[c]);
      if (sv[c] < m_min[c]) m_min[c] = sv[c];
      if (sv[c] > m_max[c]) m_max[c] = sv[c];
    end
    if (|ac) begin
      m_cnt++; m_early = 1;
      if (m_cnt >= int'(accum_len)) begin m_final = 1; m_done = 1; end
    end
  endtask

  task automatic check(string tag);
    logic [127:0] got, exp;
    got = {latest_o, min_o, max_o, avg_o};
    exp = {m_lat[1], m_lat[0], m_min[1], m_min[0], m_max[1], m_max[0], m_avg[1], m_avg[0]};
    n_chk++;
    if (got !== exp || early_valid !== m_early || final_valid !== m_final || done_pulse !== m_done) begin
      n_bad++;
      $display("FAIL %s: got %h ev%b fv%b dp%b, expected %h ev%b fv%b dp%b",
               tag, got, early_valid, final_valid, done_pulse, exp, m_early, m_final, m_done);
    end
  endtask

  task automatic step(logic [15:0] p, logic [15:0] n, logic sp, logic sn, string tag);
    @(negedge clk);
    samp_p = p; samp_n = n; stb_p = sp; stb_n = sn;
    mdl_edge();
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    glob_en = 1; det_en = 1; chp_en = 1; chn_en = 1; accum_len = 10'd8;
    wgt_p = 16'h8000; wgt_n = 16'h4000;
    samp_p = '0; samp_n = '0; stb_p = 0; stb_n = 0;
    mdl_clear();
    #11; check("R9 reset state");
    rst_n = 1;

    // R1 R2 R3 R5 R6 R7: table run, last entries land after completion and must not change anything
    foreach (VEC[i])
      step(VEC[i][31:16], VEC[i][15:0], VEC[i][33], VEC[i][32], "R1 R2 R3 R5 R6 R7 table");

    // R8: global disable clears and ignores samples
    glob_en = 0;
    step(16'h1234, 16'h4321, 1, 1, "R8 disable clears");
    step(16'h0001, 16'h0002, 1, 1, "R8 disable ignores");
    glob_en = 1;

    // R4: detector off holds everything
    step(16'h0500, 16'h0600, 1, 1, "R4 first sample");
    det_en = 0;
    step(16'h0001, 16'hFFFF, 1, 1, "R4 detector off");
    det_en = 1;

    // R4: P channel disabled, its halves stay at restart/last values
    chp_en = 0;
    step(16'h0002, 16'h0700, 1, 1, "R4 P channel off");
    chp_en = 1;

    // R3: weight zero holds average, full weight
    wgt_n = 16'h0000; wgt_p = 16'hFFFF;
    step(16'hFFFF, 16'hFFFF, 1, 1, "R3 weight zero and max");
    step(16'h0000, 16'h0000, 1, 1, "R3 weight max downward");

    // R5: length 0 acts as 1 after a restart
    glob_en = 0; accum_len = 10'd0;
    step(16'h0, 16'h0, 0, 0, "R8 restart");
    glob_en = 1;
    step(16'h0042, 16'h0024, 0, 1, "R5 length zero completes");
    step(16'h0099, 16'h0099, 1, 1, "R7 frozen after completion");

    // R5 R6: no strobe, no count
    glob_en = 0; accum_len = 10'd2;
    step(16'h0, 16'h0, 0, 0, "R8 restart");
    glob_en = 1;
    step(16'h0010, 16'h0010, 0, 0, "R6 no strobe stays invalid");
    step(16'h0010, 16'h0010, 1, 0, "R6 early valid");
    step(16'h0020, 16'h0020, 1, 0, "R5 final at length two");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule